// File: doc/BRIEF.md
# Triple-Replica Result Voter

This block sits behind three redundant copies of an arithmetic unit and turns their three result buses into one trusted result. Each cycle it compares the three buses pairwise, picks a value that at least two replicas agree on, and registers it as the voted output. In the same cycle it names the replica that stands alone: one flag per replica, plus a summary error line that a separate recovery controller watches to start repairing that replica.

When all three results differ from each other, no majority exists. The block then raises a dedicated no-majority status, keeps the per-replica flags and the error line low, and holds the voted output at its last value. An output-enable input gates the voted result. Widths, the comparator structure and the output-enable behaviour are parameters.

Top module: `tmr_vote_stage`

## Requirements
- R1: When exactly two replicas agree, the voted output one clock later equals their common value, so a replica standing alone is never the source.
- R2: When all three replicas agree, the voted output one clock later equals that value and all flags, the error line and the no-majority status are low.
- R3: The flag bus has bit 0 for replica A, bit 1 for replica B and bit 2 for replica C; a bit is high one clock after that replica differed from both others while those two agreed, and at most one bit is ever high.
- R4: The error line is high one clock after a cycle in which one replica was judged faulty, and low otherwise.
- R5: When all three results differ pairwise, the no-majority status is high one clock later while all flag bits and the error line are low.
- R6: With output enable high and no majority, the voted output keeps its previous value.
- R7: With output enable low, the voted output is zero one clock later (default variant), while flags, error line and no-majority status still follow the inputs.
- R8: A synchronous reset, active high, clears the voted output, the flags, the error line and the no-majority status at the next clock edge, whatever the inputs.
- R9: All outputs come from registers loaded on the same edge, so the voted value and its flags always describe the same input cycle, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oe | input | 1 | Output enable for the voted result |
| res_a | input | DATA_W | Result of replica A |
| res_b | input | DATA_W | Result of replica B |
| res_c | input | DATA_W | Result of replica C |
| vote_q | output | DATA_W | Registered voted result |
| bad_q | output | 3 | Registered per-replica fault flags, bit 0 = A |
| err_q | output | 1 | Registered summary error line |
| nomaj_q | output | 1 | Registered no-majority status |

## Verification
A wrong comparator or judge shows up one clock after the offending input pattern, either as a flag on the wrong replica or as an error line that disagrees with the flags. A broken selector shows as a voted value that equals the lone replica instead of the agreeing pair. A broken hold path becomes visible only when a no-majority cycle follows a valid one, so the stimulus places such cycles directly after known values and after an output-enable-low cycle.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
   localparam int unsigned NREP   = 3;
   localparam int unsigned NPAIRS = 3;
   // pair order in the equality vector: 0 = A/B, 1 = A/C, 2 = B/C
   localparam int unsigned PAIR_AB = 0;
   localparam int unsigned PAIR_AC = 1;
   localparam int unsigned PAIR_BC = 2;

   typedef enum logic [0:0] {
      CMP_FLAT  = 1'b0,
      CMP_LANES = 1'b1
   } cmp_style_e;

   // pair that does not involve replica r
   function automatic int unsigned opposite_pair(input int unsigned r);
      return NPAIRS - 1 - r;
   endfunction

   // mask of the two pairs that involve replica r
   function automatic logic [NPAIRS-1:0] own_pairs(input int unsigned r);
      logic [NPAIRS-1:0] m;
      m = '1;
      m[opposite_pair(r)] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/tmr_eq_cmp.sv
module tmr_eq_cmp
   import tmr_vote_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LANE_W    = 8,
   parameter cmp_style_e  CMP_STYLE = CMP_LANES
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   output logic              same
);
   localparam int unsigned NLANES = DATA_W / LANE_W;

   generate
      if (CMP_STYLE == CMP_FLAT) begin : g_flat
         assign same = (x == y);
      end else begin : g_lanes
         logic [NLANES-1:0] lane_same;
         for (genvar l = 0; l < NLANES; l++) begin : g_lane
            assign lane_same[l] = ~|(x[l*LANE_W +: LANE_W] ^ y[l*LANE_W +: LANE_W]);
         end
         assign same = &lane_same;
      end
   endgenerate
endmodule

// File: rtl/tmr_judge.sv
module tmr_judge
   import tmr_vote_pkg::*;
(
   input  logic [NPAIRS-1:0] pair_eq,
   output logic [NREP-1:0]   lone,
   output logic              no_major,
   output logic              any_lone
);
   generate
      for (genvar r = 0; r < NREP; r++) begin : g_rep
         localparam logic [NPAIRS-1:0] OWN = own_pairs(r);
         localparam int unsigned       OPP = opposite_pair(r);
         assign lone[r] = pair_eq[OPP] & ~|(pair_eq & OWN);
      end
   endgenerate

   assign no_major = ~|pair_eq;
   assign any_lone = |lone;
endmodule

// File: rtl/tmr_pick.sv
module tmr_pick
   import tmr_vote_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] res_a,
   input  logic [DATA_W-1:0] res_b,
   input  logic              a_agrees,
   output logic [DATA_W-1:0] picked
);
   // A is the default source whenever it matches another replica;
   // otherwise B is taken, which is right whenever B and C agree.
   always_comb begin
      if (a_agrees) picked = res_a;
      else          picked = res_b;
   end
endmodule

// File: rtl/tmr_vote_stage.sv
module tmr_vote_stage
   import tmr_vote_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LANE_W    = 8,
   parameter cmp_style_e  CMP_STYLE = CMP_LANES,
   parameter bit          OE_HOLD   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              oe,
   input  logic [DATA_W-1:0] res_a,
   input  logic [DATA_W-1:0] res_b,
   input  logic [DATA_W-1:0] res_c,
   output logic [DATA_W-1:0] vote_q,
   output logic [NREP-1:0]   bad_q,
   output logic              err_q,
   output logic              nomaj_q
);
   generate
      if (DATA_W < 1) begin : g_chk_w
         $error("tmr_vote_stage: DATA_W must be at least 1");
      end
      if (CMP_STYLE == CMP_LANES && (LANE_W < 1 || (DATA_W % LANE_W) != 0)) begin : g_chk_lane
         $error("tmr_vote_stage: LANE_W must divide DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] rep [NREP];
   assign rep[0] = res_a;
   assign rep[1] = res_b;
   assign rep[2] = res_c;

   logic [NPAIRS-1:0] pair_eq;

   generate
      for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
         localparam int unsigned LO = (p == PAIR_BC) ? 1 : 0;
         localparam int unsigned HI = (p == PAIR_AB) ? 1 : 2;
         tmr_eq_cmp #(
            .DATA_W   (DATA_W),
            .LANE_W   (LANE_W),
            .CMP_STYLE(CMP_STYLE)
         ) u_cmp (
            .x   (rep[LO]),
            .y   (rep[HI]),
            .same(pair_eq[p])
         );
      end
   endgenerate

   logic [NREP-1:0] lone;
   logic            no_major;
   logic            any_lone;

   tmr_judge u_judge (
      .pair_eq (pair_eq),
      .lone    (lone),
      .no_major(no_major),
      .any_lone(any_lone)
   );

   logic [DATA_W-1:0] picked;

   tmr_pick #(.DATA_W(DATA_W)) u_pick (
      .res_a   (res_a),
      .res_b   (res_b),
      .a_agrees(pair_eq[PAIR_AB] | pair_eq[PAIR_AC]),
      .picked  (picked)
   );

   // next voted value: disabled output either zeroes or holds
   logic [DATA_W-1:0] vote_d;

   generate
      if (OE_HOLD) begin : g_oe_hold
         always_comb begin
            if (!oe || no_major) vote_d = vote_q;
            else                 vote_d = picked;
         end
      end else begin : g_oe_zero
         always_comb begin
            if (!oe)           vote_d = '0;
            else if (no_major) vote_d = vote_q;
            else               vote_d = picked;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vote_q  <= '0;
         bad_q   <= '0;
         err_q   <= 1'b0;
         nomaj_q <= 1'b0;
      end else begin
         vote_q  <= vote_d;
         bad_q   <= lone;
         err_q   <= any_lone;
         nomaj_q <= no_major;
      end
   end
endmodule

// File: rtl/tmr_vote_chk.sv
module tmr_vote_chk
   import tmr_vote_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          OE_HOLD = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              oe,
   input logic [DATA_W-1:0] res_a,
   input logic [DATA_W-1:0] res_b,
   input logic [DATA_W-1:0] res_c,
   input logic [DATA_W-1:0] vote_q,
   input logic [NREP-1:0]   bad_q,
   input logic              err_q,
   input logic              nomaj_q
);
   logic all_diff;
   assign all_diff = (res_a != res_b) && (res_a != res_c) && (res_b != res_c);

   assert_pair_wins_R1: assert property (@(posedge clk) disable iff (rst)
      (oe && res_a != res_b && res_b == res_c) |=> (vote_q == $past(res_b)));

   assert_a_default_R2: assert property (@(posedge clk) disable iff (rst)
      (oe && (res_a == res_b || res_a == res_c)) |=> (vote_q == $past(res_a)));

   assert_flag_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bad_q));

   assert_flag_a_R3: assert property (@(posedge clk) disable iff (rst)
      (res_b == res_c && res_a != res_b) |=> (bad_q == 3'b001));

   assert_err_follows_R4: assert property (@(posedge clk) disable iff (rst)
      (res_a == res_b || res_a == res_c || res_b == res_c) && !(res_a == res_b && res_b == res_c)
      |=> err_q);

   assert_nomaj_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      all_diff |=> (nomaj_q && bad_q == '0 && !err_q));

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (oe && all_diff) |=> $stable(vote_q));

   generate
      if (!OE_HOLD) begin : g_oe_zero_chk
         assert_oe_zero_R7: assert property (@(posedge clk) disable iff (rst)
            !oe |=> (vote_q == '0));
      end
   endgenerate

   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (vote_q == '0 && bad_q == '0 && !err_q && !nomaj_q));
endmodule

bind tmr_vote_stage tmr_vote_chk #(
   .DATA_W (DATA_W),
   .OE_HOLD(OE_HOLD)
) u_vote_chk (
   .clk    (clk),
   .rst    (rst),
   .oe     (oe),
   .res_a  (res_a),
   .res_b  (res_b),
   .res_c  (res_c),
   .vote_q (vote_q),
   .bad_q  (bad_q),
   .err_q  (err_q),
   .nomaj_q(nomaj_q)
);

// File: tb/test_tmr_vote_stage.sv
module test_tmr_vote_stage;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         oe  = 1'b0;
   logic [W-1:0] ra  = '0;
   logic [W-1:0] rb  = '0;
   logic [W-1:0] rc  = '0;
   logic [W-1:0] vote_q;
   logic [2:0]   bad_q;
   logic         err_q;
   logic         nomaj_q;

   always #10 clk = ~clk;   // 50 MHz

   tmr_vote_stage #(.DATA_W(W), .LANE_W(4)) i_tmr_vote_stage (
      .clk(clk), .rst(rst), .oe(oe),
      .res_a(ra), .res_b(rb), .res_c(rc),
      .vote_q(vote_q), .bad_q(bad_q), .err_q(err_q), .nomaj_q(nomaj_q)
   );

   typedef struct {
      logic [W-1:0] vote;
      logic [2:0]   bad;
      logic         err;
      logic         nomaj;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   int           total = 0;
   int           bad_n = 0;
   logic [W-1:0] last_vote = '0;
   bit           done = 1'b0;

   // driver: set inputs at negedge, push the value due after the next posedge
   task automatic step(input logic [W-1:0] a, b, c, input logic e, input logic r,
                       input string tag);
      exp_t x;
      bit ab, ac, bc;
      @(negedge clk);
      ra = a; rb = b; rc = c; oe = e; rst = r;
      ab = (a == b); ac = (a == c); bc = (b == c);
      x.tag = tag;
      if (r) begin
         x.vote = '0; x.bad = '0; x.err = 1'b0; x.nomaj = 1'b0;
      end else begin
         x.bad   = {(!ac && !bc && ab), (!ab && !bc && ac), (!ab && !ac && bc)};
         x.err   = |x.bad;
         x.nomaj = !ab && !ac && !bc;
         if (!e)           x.vote = '0;
         else if (x.nomaj) x.vote = last_vote;
         else if (ab || ac) x.vote = a;
         else              x.vote = b;
      end
      last_vote = x.vote;
      sb.push_back(x);
   endtask

   // monitor: sample mid high phase after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() != 0) begin
            exp_t x;
            x = sb.pop_front();
            total++;
            if (vote_q !== x.vote || bad_q !== x.bad || err_q !== x.err || nomaj_q !== x.nomaj) begin
               bad_n++;
               $display("FAIL %s: got vote=%h bad=%b err=%b nomaj=%b exp vote=%h bad=%b err=%b nomaj=%b",
                        x.tag, vote_q, bad_q, err_q, nomaj_q, x.vote, x.bad, x.err, x.nomaj);
            end
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         bad_n++;
         $display("FAIL watchdog: got running exp finished");
         $display("  test done: total=%0d bad=%0d", total, bad_n);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] s;
      // R8 reset state with busy inputs
      step(16'h1234, 16'h5678, 16'h9abc, 1'b1, 1'b1, "R8 reset");
      step(16'h1111, 16'h1111, 16'h2222, 1'b1, 1'b1, "R8 reset busy");
      // R2 full agreement
      step(16'hbeef, 16'hbeef, 16'hbeef, 1'b1, 1'b0, "R2 all agree");
      // R1 R3 R4 each replica alone
      step(16'h0001, 16'h00f0, 16'h00f0, 1'b1, 1'b0, "R1 R3 R4 A alone");
      step(16'h0a0a, 16'h0b0b, 16'h0a0a, 1'b1, 1'b0, "R1 R3 R4 B alone");
      step(16'hc3c3, 16'hc3c3, 16'h0000, 1'b1, 1'b0, "R1 R3 R4 C alone");
      // R5 R6 no majority holds last value
      step(16'h0001, 16'h0002, 16'h0003, 1'b1, 1'b0, "R5 R6 no majority");
      step(16'hffff, 16'h7fff, 16'h3fff, 1'b1, 1'b0, "R5 R6 no majority again");
      // R7 output enable low, flags still live
      step(16'h4444, 16'h5555, 16'h5555, 1'b0, 1'b0, "R7 oe low A alone");
      step(16'h9999, 16'h9999, 16'h9999, 1'b0, 1'b0, "R7 oe low agree");
      step(16'h0010, 16'h0020, 16'h0030, 1'b1, 1'b0, "R6 hold after oe low");
      step(16'h00aa, 16'h00aa, 16'h00ab, 1'b1, 1'b0, "R9 back to valid");
      // single-bit differences in top and bottom lanes
      step(16'h8000, 16'h0000, 16'h0000, 1'b1, 1'b0, "R1 R3 top bit A");
      step(16'h0000, 16'h0000, 16'h0001, 1'b1, 1'b0, "R1 R3 low bit C");
      // R8 mid-run reset
      step(16'h7777, 16'h7777, 16'h7777, 1'b1, 1'b1, "R8 mid reset");
      step(16'h0001, 16'h0002, 16'h0003, 1'b1, 1'b0, "R6 hold after reset");
      // R9 mixed back-to-back patterns
      s = 16'hace1;
      for (int i = 0; i < 60; i++) begin
         logic [W-1:0] a, b, c;
         s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
         a = s; b = s; c = s;
         case (i % 6)
            0: a = s ^ 16'h0100;
            1: b = ~s;
            2: c = s + 16'd1;
            3: begin b = s ^ 16'h0001; c = s ^ 16'h0002; end
            4: ;
            default: begin a = s ^ 16'h8000; b = s ^ 16'h8000; end
         endcase
         step(a, b, c, (i % 7) != 3, 1'b0, "R9 mixed run");
      end
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad_n);
      $finish;
   end
endmodule